// File: doc/BRIEF.md
# Edge-Latched Maskable Interrupt Controller

This block gathers eight external interrupt lines into one prioritised-level bus interrupt request. Every line has its own static edge choice (rising or falling). When a line shows its chosen edge, a sticky latch for that line is set and stays set until software clears it by writing a one to the matching bit of a clear register. A mask register selects which latched lines count as pending. A control register enables the bus request, and a status bit reports whether anything is pending, whether or not the request is enabled.

The request is driven on one of seven levels, chosen by a static 3-bit setting, where zero means no level. When the host runs an acknowledge cycle at a level, the block either claims it and returns its stored vector byte, or passes the acknowledge on to the next device in the chain. Host access uses a small register port: a 3-bit register index, a write strobe, write data and combinational read data. There are three resets. Power-on reset clears everything. System reset and the soft reset written through the control register return the mask and enable to their defaults, but they leave the line latches as they are.

Top module: `irq_edge_ctrl`

## Requirements
- R1: A line whose `edge_sel` bit is 0 latches on a low-to-high transition of its pin, and a line whose bit is 1 latches on a high-to-low transition. The opposite transition leaves the latch unchanged.
- R2: Reading index 0 returns the eight latch bits, with bit n for line n. These are not the current pin levels. A set latch stays set after its pin returns to its earlier level.
- R3: Writing index 3 clears latch n for every data bit n that is 1. Bits that are 0 leave their latches unchanged. Reading index 3 returns 00h. If an edge is detected on a line in the same cycle as a clear of that line, the latch ends up set.
- R4: Index 2 is the read/write mask, where 1 passes a line and 0 blocks it. Reading index 1 returns the pending byte, which is the latches ANDed with the mask.
- R5: Writing index 5 with bit 4 set is a soft reset. It sets the mask to 00h and the enable to 0 and keeps the vector. System reset (`rst_n` low) sets the mask, enable and vector to 00h/0. Neither soft reset nor system reset changes the latches. Only power-on reset (`por_n` low) clears the latches.
- R6: At index 5, bit 3 is the read/write request enable. The read-only bit 2 is the OR of all pending bits, and it is valid while the enable is 0. All other read bits are 0.
- R7: `irq_req` bit k-1 is high if and only if the enable is 1, at least one pending bit is set, and `irq_level` equals k (1 to 7). When `irq_level` is 0, no request bit is ever high.
- R8: While `iack_in` is high, `iack_take` is high and `iack_vector` shows the vector if `iack_level` equals `irq_level` and the block is requesting. In every other case `iack_pass` is high and `iack_vector` is 00h.
- R9: Index 4 is the read/write vector byte, and it is 00h after power-on reset.
- R10: Pins pass through a two-stage synchronizer before edge detection. A pulse held for two clock cycles is latched, and the latch is visible at index 0 within four cycles of the pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low; clears everything including latches |
| rst_n | input | 1 | System reset, active low; latches are kept |
| line_in | input | 8 | Asynchronous external interrupt pins |
| edge_sel | input | 8 | Static per-line edge choice: 0 rising, 1 falling |
| irq_level | input | 3 | Static request level, 0 means none |
| bus_addr | input | 3 | Register index |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| irq_req | output | 7 | One-hot bus request, bit k-1 for level k |
| iack_in | input | 1 | Acknowledge cycle in progress |
| iack_level | input | 3 | Level being acknowledged |
| iack_take | output | 1 | Block claims the acknowledge |
| iack_pass | output | 1 | Acknowledge is handed to the next device |
| iack_vector | output | 8 | Vector byte while claiming, else 00h |

## Verification
The hardest case to reach from the ports is an edge and a software clear that land on the same line in the same clock. The internal edge pulse occurs two synchronizer stages after the pin moves, so the bench changes the pin on a falling clock edge and counts exactly two rising edges. It then raises the clear write so that the write is sampled on the same rising edge at which the detected edge would set the latch, and it checks that the latch survives. Around that case, the bench sweeps every line under both edge choices with both the inactive and the active transition, every request level, and every acknowledge level.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;
  // request level encoding
  localparam int LVL_W = 3;
  localparam int N_LVL = (1 << LVL_W) - 1;
  localparam int IDX_W = 3;

  // register indices
  localparam logic [IDX_W-1:0] RI_LATCH = 3'd0;
  localparam logic [IDX_W-1:0] RI_PEND  = 3'd1;
  localparam logic [IDX_W-1:0] RI_MASK  = 3'd2;
  localparam logic [IDX_W-1:0] RI_CLEAR = 3'd3;
  localparam logic [IDX_W-1:0] RI_VECT  = 3'd4;
  localparam logic [IDX_W-1:0] RI_CTRL  = 3'd5;

  // control / status bit positions
  localparam int CTL_SUM_BIT  = 2;
  localparam int CTL_EN_BIT   = 3;
  localparam int CTL_SRST_BIT = 4;

  // one-hot request vector for a level, empty when inactive or level 0
  function automatic logic [N_LVL-1:0] f_level_onehot(input logic [LVL_W-1:0] lvl,
                                                      input logic active);
    logic [N_LVL-1:0] r;
    r = '0;
    if (active && lvl != '0) r[int'(lvl) - 1] = 1'b1;
    return r;
  endfunction

  // latch update: edge wins over clear
  function automatic logic f_latch_next(input logic cur, input logic edge_hit,
                                        input logic clr);
    return edge_hit | (cur & ~clr);
  endfunction
endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int N_LINES = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] edge_sel,
  output logic [N_LINES-1:0] edge_vec
);
  localparam int CHAIN = SYNC_STAGES + 1;
  localparam int WARM_W = $clog2(CHAIN + 1);
  localparam logic [WARM_W-1:0] WARM_DONE = WARM_W'(CHAIN);

  // warm-up: no edge is reported until the chain holds real pin samples
  logic [WARM_W-1:0] warm_q;
  logic              armed;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                 warm_q <= '0;
    else if (warm_q != WARM_DONE) warm_q <= warm_q + 1'b1;
  end
  assign armed = (warm_q == WARM_DONE);

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [CHAIN-1:0] chain_q;
    logic             rise_w, fall_w;

    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) chain_q <= '0;
      else        chain_q <= {chain_q[CHAIN-2:0], line_in[g]};
    end

    assign rise_w = chain_q[CHAIN-2] & ~chain_q[CHAIN-1];
    assign fall_w = ~chain_q[CHAIN-2] & chain_q[CHAIN-1];
    assign edge_vec[g] = armed & (edge_sel[g] ? fall_w : rise_w);

    // R1: a detected edge on a rising-select line means the synced level just went high
    p_edge_level_r1: assert property (@(posedge clk) disable iff (!por_n)
      (edge_vec[g] && !edge_sel[g]) |-> chain_q[CHAIN-2]);
  end

  // R10: nothing is reported before the synchronizer is filled
  p_armed_before_edge_r10: assert property (@(posedge clk) disable iff (!por_n)
    (edge_vec != '0) |-> armed);
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank
  import irq_edge_pkg::*;
#(
  parameter int N_LINES = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [N_LINES-1:0] edge_vec,
  input  logic [N_LINES-1:0] clr_vec,
  output logic [N_LINES-1:0] latch_q
);
  logic [N_LINES-1:0] latch_d;

  for (genvar g = 0; g < N_LINES; g++) begin : g_bit
    assign latch_d[g] = f_latch_next(latch_q[g], edge_vec[g], clr_vec[g]);
  end

  // only power-on reset reaches the latches
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) latch_q <= '0;
    else        latch_q <= latch_d;
  end

  // R1: every detected edge leaves its latch set, even against a clear (R3)
  p_edge_sets_r1: assert property (@(posedge clk) disable iff (!por_n)
    (edge_vec != '0) |=> (($past(edge_vec) & ~latch_q) == '0));

  // R2: a set latch not being cleared stays set
  p_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    ((latch_q & ~clr_vec) != '0) |=> ((($past(latch_q) & ~$past(clr_vec)) & ~latch_q) == '0));

  // R3: a latch only rises through an edge
  p_no_spurious_set_r3: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> ((latch_q & ~$past(latch_q) & ~$past(edge_vec)) == '0));
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import irq_edge_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DW = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [IDX_W-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  input  logic [N_LINES-1:0] latch_q,
  output logic [N_LINES-1:0] clr_vec,
  output logic [N_LINES-1:0] pend,
  output logic               pend_any,
  output logic               enable_q,
  output logic [DW-1:0]      vector_q
);
  localparam int PAD = DW - N_LINES;

  logic [N_LINES-1:0] mask_q;
  logic               wr_mask, wr_ctrl, wr_vect, wr_clear;
  logic               srst_pulse;

  assign wr_mask    = bus_wr && (bus_addr == RI_MASK);
  assign wr_ctrl    = bus_wr && (bus_addr == RI_CTRL);
  assign wr_vect    = bus_wr && (bus_addr == RI_VECT);
  assign wr_clear   = bus_wr && (bus_addr == RI_CLEAR);
  assign srst_pulse = wr_ctrl && bus_wdata[CTL_SRST_BIT];

  assign clr_vec  = wr_clear ? bus_wdata[N_LINES-1:0] : '0;
  assign pend     = latch_q & mask_q;
  assign pend_any = |pend;

  // mask and enable: system reset, power-on reset and soft reset
  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) begin
      mask_q   <= '0;
      enable_q <= 1'b0;
    end else if (srst_pulse) begin
      mask_q   <= '0;
      enable_q <= 1'b0;
    end else begin
      if (wr_mask) mask_q   <= bus_wdata[N_LINES-1:0];
      if (wr_ctrl) enable_q <= bus_wdata[CTL_EN_BIT];
    end
  end

  // vector: kept across soft reset
  always_ff @(posedge clk or negedge por_n or negedge rst_n) begin
    if (!por_n || !rst_n) vector_q <= '0;
    else if (wr_vect)     vector_q <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RI_LATCH: bus_rdata = {{PAD{1'b0}}, latch_q};
      RI_PEND:  bus_rdata = {{PAD{1'b0}}, pend};
      RI_MASK:  bus_rdata = {{PAD{1'b0}}, mask_q};
      RI_VECT:  bus_rdata = vector_q;
      RI_CTRL: begin
        bus_rdata[CTL_EN_BIT]  = enable_q;
        bus_rdata[CTL_SUM_BIT] = pend_any;
      end
      default:  bus_rdata = '0;
    endcase
  end

  // R5: soft reset leaves mask and enable cleared
  p_soft_reset_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    srst_pulse |=> (mask_q == '0 && !enable_q));

  // R3: the clear index reads as zero
  p_clear_reads_zero_r3: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_addr == RI_CLEAR) |-> (bus_rdata == '0));

  // R6: summary bit tracks pending regardless of enable
  p_summary_r6: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (bus_addr == RI_CTRL) |-> (bus_rdata[CTL_SUM_BIT] == (pend != '0)));
endmodule

// File: rtl/irq_requester.sv
module irq_requester
  import irq_edge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             enable,
  input  logic             pend_any,
  input  logic [LVL_W-1:0] irq_level,
  input  logic [DW-1:0]    vector,
  input  logic             iack_in,
  input  logic [LVL_W-1:0] iack_level,
  output logic [N_LVL-1:0] irq_req,
  output logic             iack_take,
  output logic             iack_pass,
  output logic [DW-1:0]    iack_vector
);
  logic requesting;

  assign irq_req     = f_level_onehot(irq_level, enable && pend_any);
  assign requesting  = (irq_req != '0);
  assign iack_take   = iack_in && requesting && (iack_level == irq_level);
  assign iack_pass   = iack_in && !iack_take;
  assign iack_vector = iack_take ? vector : '0;

  // R7: at most one level driven
  p_req_onehot_r7: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(irq_req));

  // R7: request needs enable and something pending
  p_req_needs_enable_r7: assert property (@(posedge clk) disable iff (!por_n)
    (irq_req != '0) |-> (enable && pend_any));

  // R8: claim and pass never together, and only during an acknowledge
  p_ack_exclusive_r8: assert property (@(posedge clk) disable iff (!por_n)
    (iack_take || iack_pass) |-> (iack_in && !(iack_take && iack_pass)));
endmodule

// File: rtl/irq_edge_ctrl.sv
module irq_edge_ctrl
  import irq_edge_pkg::*;
#(
  parameter int N_LINES = 8,
  parameter int DW = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] edge_sel,
  input  logic [LVL_W-1:0]   irq_level,
  input  logic [IDX_W-1:0]   bus_addr,
  input  logic               bus_wr,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic [N_LVL-1:0]   irq_req,
  input  logic               iack_in,
  input  logic [LVL_W-1:0]   iack_level,
  output logic               iack_take,
  output logic               iack_pass,
  output logic [DW-1:0]      iack_vector
);
  logic [N_LINES-1:0] edge_vec;
  logic [N_LINES-1:0] clr_vec;
  logic [N_LINES-1:0] latch_q;
  logic [N_LINES-1:0] pend;
  logic               pend_any;
  logic               enable_q;
  logic [DW-1:0]      vector_q;

  irq_line_sync #(.N_LINES(N_LINES), .SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .por_n(por_n), .line_in(line_in), .edge_sel(edge_sel),
    .edge_vec(edge_vec));

  irq_latch_bank #(.N_LINES(N_LINES)) latch_i (
    .clk(clk), .por_n(por_n), .edge_vec(edge_vec), .clr_vec(clr_vec),
    .latch_q(latch_q));

  irq_regs #(.N_LINES(N_LINES), .DW(DW)) regs_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .latch_q(latch_q), .clr_vec(clr_vec), .pend(pend), .pend_any(pend_any),
    .enable_q(enable_q), .vector_q(vector_q));

  irq_requester #(.DW(DW)) req_i (
    .clk(clk), .por_n(por_n), .enable(enable_q), .pend_any(pend_any),
    .irq_level(irq_level), .vector(vector_q), .iack_in(iack_in),
    .iack_level(iack_level), .irq_req(irq_req), .iack_take(iack_take),
    .iack_pass(iack_pass), .iack_vector(iack_vector));

  // R4: pending never shows a masked-off or unlatched line
  p_pend_subset_r4: assert property (@(posedge clk) disable iff (!por_n)
    ((pend & ~latch_q) == '0));
endmodule

// File: tb/irq_edge_ctrl_tb_top.sv
module irq_edge_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       por_n, rst_n;
  logic [7:0] line_in, edge_sel;
  logic [2:0] irq_level, bus_addr, iack_level;
  logic       bus_wr, iack_in;
  logic [7:0] bus_wdata, bus_rdata, iack_vector;
  logic [6:0] irq_req;
  logic       iack_take, iack_pass;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  irq_edge_ctrl dut_i (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .line_in(line_in),
    .edge_sel(edge_sel), .irq_level(irq_level), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .iack_in(iack_in), .iack_level(iack_level),
    .iack_take(iack_take), .iack_pass(iack_pass), .iack_vector(iack_vector));

  function automatic logic [6:0] exp_req(input int lvl, input bit act);
    if (!act || lvl == 0) return 7'd0;
    return 7'(1 << (lvl - 1));
  endfunction

  function automatic logic [7:0] exp_status(input bit en, input logic [7:0] p);
    return {4'd0, en, (p != 8'd0), 2'd0};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] m, lat;
    por_n = 0; rst_n = 0; line_in = 0; edge_sel = 0; irq_level = 0;
    bus_addr = 0; bus_wr = 0; bus_wdata = 0; iack_in = 0; iack_level = 0;
    repeat (4) @(negedge clk);
    por_n = 1; rst_n = 1;
    repeat (6) @(negedge clk);

    // reset state (R2, R4, R6, R9)
    rd(3'd0, d); check("R2 reset latch", d, 8'h00);
    rd(3'd1, d); check("R4 reset pending", d, 8'h00);
    rd(3'd2, d); check("R4 reset mask", d, 8'h00);
    rd(3'd4, d); check("R9 reset vector", d, 8'h00);
    rd(3'd5, d); check("R6 reset status", d, 8'h00);
    check("R7 reset request", {1'b0, irq_req}, 8'h00);

    // per-line edge sweep under both edge choices (R1, R2, R3)
    for (int s = 0; s < 2; s++) begin
      edge_sel = (s == 1) ? 8'hFF : 8'h00;
      line_in  = (s == 1) ? 8'h00 : 8'hFF;  // level reached by the active edge
      settle();
      wr(3'd3, 8'hFF);
      rd(3'd0, d); check("R3 sweep start clear", d, 8'h00);
      for (int i = 0; i < 8; i++) begin
        logic start_lvl;
        start_lvl = line_in[i];
        line_in[i] = ~start_lvl; settle();  // inactive transition
        rd(3'd0, d); check($sformatf("R1 inactive edge s=%0d line=%0d", s, i), d, 8'h00);
        line_in[i] = start_lvl; settle();   // active transition
        rd(3'd0, d); check($sformatf("R1 active edge s=%0d line=%0d", s, i), d, 8'(1 << i));
        line_in[i] = ~start_lvl; settle();  // pin leaves, latch stays
        rd(3'd0, d); check($sformatf("R2 sticky s=%0d line=%0d", s, i), d, 8'(1 << i));
        line_in[i] = start_lvl; settle();
        wr(3'd3, 8'(1 << i));
        rd(3'd0, d); check($sformatf("R3 clear s=%0d line=%0d", s, i), d, 8'h00);
      end
    end

    // clear with zero bits, clear read (R3)
    edge_sel = 8'h00; line_in = 8'h00; settle();
    line_in = 8'hFF; settle();
    rd(3'd0, d); check("R1 all lines latched", d, 8'hFF);
    wr(3'd3, 8'h00);
    rd(3'd0, d); check("R3 zero write no effect", d, 8'hFF);
    wr(3'd3, 8'hC3);
    rd(3'd0, d); check("R3 partial clear", d, 8'h3C);
    rd(3'd3, d); check("R3 clear reads zero", d, 8'h00);

    // mask / pending / summary sweep with enable off (R4, R6)
    lat = 8'h3C;
    for (int k = 0; k < 8; k++) begin
      m = 8'(1 << k) | 8'(8'h80 >> k);
      wr(3'd2, m);
      rd(3'd2, d); check($sformatf("R4 mask readback k=%0d", k), d, m);
      rd(3'd1, d); check($sformatf("R4 pending k=%0d", k), d, m & lat);
      rd(3'd5, d); check($sformatf("R6 summary enable off k=%0d", k), d, exp_status(0, m & lat));
      check($sformatf("R7 no request while disabled k=%0d", k), {1'b0, irq_req}, 8'h00);
    end

    // level sweep (R7)
    wr(3'd2, 8'h04);
    wr(3'd5, 8'h08);
    rd(3'd5, d); check("R6 enable readback", d, exp_status(1, 8'h04));
    for (int lv = 0; lv < 8; lv++) begin
      @(negedge clk); irq_level = 3'(lv);
      #1 check($sformatf("R7 level=%0d", lv), {1'b0, irq_req}, {1'b0, exp_req(lv, 1)});
    end
    wr(3'd2, 8'h40);  // masked-on line not latched
    @(negedge clk); #1 check("R7 no pending no request", {1'b0, irq_req}, 8'h00);
    wr(3'd2, 8'h04);

    // vector and acknowledge sweep (R8, R9)
    wr(3'd4, 8'hA7);
    rd(3'd4, d); check("R9 vector readback", d, 8'hA7);
    irq_level = 3'd5;
    for (int a = 0; a < 8; a++) begin
      @(negedge clk); iack_in = 1; iack_level = 3'(a);
      #1;
      check($sformatf("R8 take lvl=%0d", a), {7'd0, iack_take}, {7'd0, (a == 5)});
      check($sformatf("R8 pass lvl=%0d", a), {7'd0, iack_pass}, {7'd0, (a != 5)});
      check($sformatf("R8 vector lvl=%0d", a), iack_vector, (a == 5) ? 8'hA7 : 8'h00);
    end
    @(negedge clk); iack_in = 0; #1;
    check("R8 idle no pass", {6'd0, iack_take, iack_pass}, 8'h00);
    wr(3'd5, 8'h00);
    @(negedge clk); iack_in = 1; iack_level = 3'd5; #1;
    check("R8 not requesting passes", {6'd0, iack_take, iack_pass}, 8'h01);
    @(negedge clk); iack_in = 0;

    // edge and clear in the same cycle (R3)
    wr(3'd3, 8'hFF);
    line_in = 8'h00; settle();
    wr(3'd3, 8'hFF);
    @(negedge clk); line_in[1] = 1'b1;          // sampled at next rising edge
    @(negedge clk);                              // first stage loaded
    @(negedge clk);                              // second stage loaded: edge pending
    bus_addr = 3'd3; bus_wdata = 8'h02; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd0, d); check("R3 edge beats same-cycle clear", d, 8'h02);
    wr(3'd3, 8'h02);
    rd(3'd0, d); check("R3 later clear takes", d, 8'h00);

    // two-cycle pulses (R10)
    edge_sel = 8'h80; line_in = 8'h80; settle();
    wr(3'd3, 8'hFF);
    @(negedge clk); line_in[0] = 1'b1;
    repeat (2) @(negedge clk); line_in[0] = 1'b0;
    repeat (2) @(negedge clk);
    rd(3'd0, d); check("R10 rising two-cycle pulse", d, 8'h01);
    @(negedge clk); line_in[7] = 1'b0;
    repeat (2) @(negedge clk); line_in[7] = 1'b1;
    repeat (2) @(negedge clk);
    rd(3'd0, d); check("R10 falling two-cycle pulse", d, 8'h81);

    // soft reset, system reset, power-on reset (R5)
    wr(3'd2, 8'hFF); wr(3'd5, 8'h08); wr(3'd4, 8'h5A);
    wr(3'd5, 8'h18);  // enable bit with soft reset: soft reset wins
    rd(3'd2, d); check("R5 soft reset mask", d, 8'h00);
    rd(3'd5, d); check("R5 soft reset enable", d, 8'h00);
    rd(3'd4, d); check("R5 soft reset keeps vector", d, 8'h5A);
    rd(3'd0, d); check("R5 soft reset keeps latches", d, 8'h81);
    wr(3'd2, 8'hFF); wr(3'd5, 8'h08);
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    rd(3'd2, d); check("R5 system reset mask", d, 8'h00);
    rd(3'd4, d); check("R5 system reset vector", d, 8'h00);
    rd(3'd5, d); check("R5 system reset enable", d, 8'h00);
    rd(3'd0, d); check("R5 system reset keeps latches", d, 8'h81);
    @(negedge clk); por_n = 0;
    repeat (2) @(negedge clk); por_n = 1;
    repeat (6) @(negedge clk);
    rd(3'd0, d); check("R5 power-on clears latches", d, 8'h00);

    summary();
    $finish;
  end
endmodule